// File: doc/BRIEF.md
# NaN Format Converter

This block changes a NaN from one binary floating-point width to another (16-bit half, 32-bit single, 64-bit double) while keeping its sign and as much of its payload as the destination can hold. The source mantissa is placed at the top of a 64-bit intermediate word, and the destination mantissa is read from the top of that word. Widening therefore appends zero bits below the payload, and narrowing drops the low payload bits. A flag reports that the source NaN was signaling.

Two mode inputs shape the result. The polarity input chooses which value of the mantissa's leading bit marks a signaling NaN. The default-NaN input replaces every result with the destination's canonical NaN. A payload that becomes all zeros after truncation would read as an infinity, so the canonical NaN takes its place. A signaling NaN passes through with its leading mantissa bit unchanged, and the caller quiets it if needed. Only NaN inputs are within the contract. A parameter chooses between a registered output stage and a purely combinational path.

Top module: `nanconv_top`

## Requirements
- R1: `src_fmt` and `dst_fmt` use code 0 for half (value in bits 15:0), 1 for single (bits 31:0) and 2 for double (bits 63:0). Code 3 behaves as double. `dst_val` is right-aligned, and every bit above the destination width is zero.
- R2: With `snan_inv`=0, a source whose leading mantissa bit (bit 9, 22 or 51) is 0 with the rest of the mantissa nonzero is signaling and sets `invalid`=1. A source whose leading mantissa bit is 1 gives `invalid`=0.
- R3: With `snan_inv`=1 the two tests swap. A leading mantissa bit of 1 is signaling and sets `invalid`=1. A leading bit of 0 is quiet and gives `invalid`=0.
- R4: Outside the default cases, `dst_val` holds the source sign in the destination's top bit, an all-ones exponent, and a mantissa whose leading bits equal the source mantissa. When widening, the lower bits are zero.
- R5: When narrowing, the destination mantissa is the leading destination-width bits of the source mantissa. The lower source bits are dropped.
- R6: If the mantissa that remains after the conversion is zero, `dst_val` is the destination's default NaN.
- R7: With `dflt_mode`=1, `dst_val` is always the destination's default NaN, and `invalid` still reports a signaling source.
- R8: With `snan_inv`=0, the default NaNs are 0xFE00 (half), 0xFFC00000 (single) and 0xFFF8000000000000 (double). With `snan_inv`=1 they are 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF.
- R9: A signaling source is not quieted. Its leading mantissa bit appears unchanged in the converted result.
- R10: Input bits above the source width have no effect on `dst_val` or `invalid`.
- R11: With `OUT_REG`=1, outputs follow the inputs of the previous clock edge and are zero while `rst` is high. With `OUT_REG`=0, outputs follow the inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| src_val | input | 64 | Source NaN, right-aligned |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| snan_inv | input | 1 | 1 selects the inverted signaling-bit polarity |
| dflt_mode | input | 1 | 1 forces the default NaN result |
| dst_val | output | 64 | Converted NaN, right-aligned, upper bits zero |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The bench instantiates the block twice. One copy uses the default `OUT_REG`=1 and the other uses `OUT_REG`=0, and both are driven from the same stimulus. This covers both the one-cycle registered timing with its reset value and the direct combinational path, and it checks that the two variants compute identical results. Every source/destination pair is covered, including the reserved format code, under both polarities and with the default-NaN mode set and clear. The stimulus includes payloads chosen to vanish on narrowing and inputs with garbage in the unused upper bits.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

    localparam int MID_W = 64;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    // Left-aligned intermediate: payload occupies the top bits of frac.
    typedef struct packed {
        logic             sign;
        logic [MID_W-1:0] frac;
    } mid_nan_t;

    function automatic int man_w(fmt_e f);
        case (f)
            FMT_HALF:   return 10;
            FMT_SINGLE: return 23;
            default:    return 52;
        endcase
    endfunction

    function automatic int exp_w(fmt_e f);
        case (f)
            FMT_HALF:   return 5;
            FMT_SINGLE: return 8;
            default:    return 11;
        endcase
    endfunction

    function automatic int fmt_w(fmt_e f);
        return 1 + exp_w(f) + man_w(f);
    endfunction

    // Shift that moves the mantissa to the top of the intermediate.
    function automatic int mid_shift(fmt_e f);
        return MID_W - man_w(f);
    endfunction

    function automatic logic [63:0] default_nan(fmt_e f, logic inv_pol);
        logic [63:0] r;
        case (f)
            FMT_HALF:   r = inv_pol ? 64'h0000_0000_0000_7DFF : 64'h0000_0000_0000_FE00;
            FMT_SINGLE: r = inv_pol ? 64'h0000_0000_7FBF_FFFF : 64'h0000_0000_FFC0_0000;
            default:    r = inv_pol ? 64'h7FF7_FFFF_FFFF_FFFF : 64'hFFF8_0000_0000_0000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nanconv_classify.sv
module nanconv_classify
    import nanconv_pkg::*;
(
    input  logic [63:0] raw,
    input  fmt_e        fmt,
    input  logic        inv_pol,
    output logic        signaling
);
    int          mw;
    logic [63:0] mant;
    logic        lead;
    logic        tail_nz;
    logic        sig_conv;
    logic        quiet_conv;

    always_comb begin
        mw         = man_w(fmt);
        mant       = raw & ((64'd1 << mw) - 64'd1);
        lead       = ((mant >> (mw - 1)) & 64'd1) != 64'd0;
        tail_nz    = (mant & ((64'd1 << (mw - 1)) - 64'd1)) != 64'd0;
        quiet_conv = lead;
        sig_conv   = !lead && tail_nz;
        signaling  = inv_pol ? quiet_conv : sig_conv;
    end
endmodule

// File: rtl/nanconv_unpack.sv
module nanconv_unpack
    import nanconv_pkg::*;
(
    input  logic [63:0] raw,
    input  fmt_e        fmt,
    output mid_nan_t    mid
);
    int sh;
    int sp;

    always_comb begin
        sh       = mid_shift(fmt);
        sp       = fmt_w(fmt) - 1;
        mid.sign = ((raw >> sp) & 64'd1) != 64'd0;
        mid.frac = raw << sh;
    end
endmodule

// File: rtl/nanconv_pack.sv
module nanconv_pack
    import nanconv_pkg::*;
(
    input  mid_nan_t    mid,
    input  fmt_e        fmt,
    input  logic        inv_pol,
    input  logic        force_dflt,
    output logic [63:0] packed_val
);
    int          sh;
    int          mw;
    int          ew;
    logic [63:0] mant;
    logic [63:0] emask;
    logic [63:0] sbit;

    always_comb begin
        sh    = mid_shift(fmt);
        mw    = man_w(fmt);
        ew    = exp_w(fmt);
        mant  = mid.frac >> sh;
        emask = (64'd1 << ew) - 64'd1;
        sbit  = {63'd0, mid.sign} << (fmt_w(fmt) - 1);
        if (force_dflt || mant == 64'd0)
            packed_val = default_nan(fmt, inv_pol);
        else
            packed_val = sbit | (emask << mw) | mant;
    end
endmodule

// File: rtl/nanconv_top.sv
module nanconv_top
    import nanconv_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] src_val,
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    input  logic        snan_inv,
    input  logic        dflt_mode,
    output logic [63:0] dst_val,
    output logic        invalid
);
    fmt_e        sf;
    fmt_e        df;
    mid_nan_t    mid;
    logic        sig_src;
    logic [63:0] conv_val;

    assign sf = fmt_e'(src_fmt);
    assign df = fmt_e'(dst_fmt);

    nanconv_classify u_cls (
        .raw       (src_val),
        .fmt       (sf),
        .inv_pol   (snan_inv),
        .signaling (sig_src)
    );

    nanconv_unpack u_unp (
        .raw (src_val),
        .fmt (sf),
        .mid (mid)
    );

    nanconv_pack u_pck (
        .mid        (mid),
        .fmt        (df),
        .inv_pol    (snan_inv),
        .force_dflt (dflt_mode),
        .packed_val (conv_val)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    dst_val <= 64'd0;
                    invalid <= 1'b0;
                end else begin
                    dst_val <= conv_val;
                    invalid <= sig_src;
                end
            end
        end else begin : g_comb
            assign dst_val = conv_val;
            assign invalid = sig_src;
        end
    endgenerate
endmodule

// File: rtl/nanconv_chk.sv
module nanconv_chk
    import nanconv_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] src_val,
    input logic [1:0]  src_fmt,
    input logic [1:0]  dst_fmt,
    input logic        snan_inv,
    input logic        dflt_mode,
    input logic [63:0] dst_val,
    input logic        invalid
);
    logic [63:0] p_src;
    logic [1:0]  p_sf;
    logic [1:0]  p_df;
    logic        p_inv;
    logic        p_dm;
    logic        p_ok;

    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    p_ok <= 1'b0;
                end else begin
                    p_ok <= 1'b1;
                end
                p_src <= src_val;
                p_sf  <= src_fmt;
                p_df  <= dst_fmt;
                p_inv <= snan_inv;
                p_dm  <= dflt_mode;
            end
        end else begin : g_now
            assign p_ok  = 1'b1;
            assign p_src = src_val;
            assign p_sf  = src_fmt;
            assign p_df  = dst_fmt;
            assign p_inv = snan_inv;
            assign p_dm  = dflt_mode;
        end
    endgenerate

    fmt_e        cf_s;
    fmt_e        cf_d;
    logic [63:0] c_dnan;
    logic [63:0] c_exp;
    logic [63:0] c_man;
    logic        c_hi_clear;
    logic        c_src_lead;
    logic        c_src_sign;
    logic        c_dst_sign;

    always_comb begin
        cf_s       = fmt_e'(p_sf);
        cf_d       = fmt_e'(p_df);
        c_dnan     = default_nan(cf_d, p_inv);
        c_man      = dst_val & ((64'd1 << man_w(cf_d)) - 64'd1);
        c_exp      = (dst_val >> man_w(cf_d)) & ((64'd1 << exp_w(cf_d)) - 64'd1);
        c_hi_clear = (fmt_w(cf_d) == 64) ? 1'b1 : ((dst_val >> fmt_w(cf_d)) == 64'd0);
        c_src_lead = ((p_src >> (man_w(cf_s) - 1)) & 64'd1) != 64'd0;
        c_src_sign = ((p_src >> (fmt_w(cf_s) - 1)) & 64'd1) != 64'd0;
        c_dst_sign = ((dst_val >> (fmt_w(cf_d) - 1)) & 64'd1) != 64'd0;
    end

    AST_DFLT_FORCED: assert property (@(posedge clk) disable iff (rst)
        (p_ok && p_dm) |-> (dst_val == c_dnan)); // R7

    AST_OUT_IS_NAN: assert property (@(posedge clk) disable iff (rst)
        p_ok |-> (c_exp == ((64'd1 << exp_w(cf_d)) - 64'd1) && c_man != 64'd0)); // R4

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        p_ok |-> c_hi_clear); // R1

    AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (p_ok && !p_inv && c_src_lead) |-> !invalid); // R2

    AST_INV_LEAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (p_ok && p_inv && c_src_lead) |-> invalid); // R3

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (p_ok && !p_dm) |-> (c_dst_sign == c_src_sign || dst_val == c_dnan)); // R4
endmodule

bind nanconv_top nanconv_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_val   (src_val),
    .src_fmt   (src_fmt),
    .dst_fmt   (dst_fmt),
    .snan_inv  (snan_inv),
    .dflt_mode (dflt_mode),
    .dst_val   (dst_val),
    .invalid   (invalid)
);

// File: tb/sim_nanconv_top.sv
module sim_nanconv_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_val = 64'd0;
    logic [1:0]  src_fmt = 2'd0;
    logic [1:0]  dst_fmt = 2'd0;
    logic        snan_inv = 1'b0;
    logic        dflt_mode = 1'b0;
    logic [63:0] out_r;
    logic        inv_r;
    logic [63:0] out_c;
    logic        inv_c;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] last_out;
    logic        last_flag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nanconv_top #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .src_val(src_val), .src_fmt(src_fmt),
        .dst_fmt(dst_fmt), .snan_inv(snan_inv), .dflt_mode(dflt_mode),
        .dst_val(out_r), .invalid(inv_r)
    );

    nanconv_top #(.OUT_REG(1'b0)) u1 (
        .clk(clk), .rst(rst), .src_val(src_val), .src_fmt(src_fmt),
        .dst_fmt(dst_fmt), .snan_inv(snan_inv), .dflt_mode(dflt_mode),
        .dst_val(out_c), .invalid(inv_c)
    );

    function automatic int m_bits(input logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
    endfunction

    function automatic int e_bits(input logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
    endfunction

    function automatic logic [63:0] dnan(input logic [1:0] f, input logic inv);
        if (f == 2'd0) return inv ? 64'h7DFF : 64'hFE00;
        if (f == 2'd1) return inv ? 64'h7FBFFFFF : 64'hFFC00000;
        return inv ? 64'h7FF7FFFFFFFFFFFF : 64'hFFF8000000000000;
    endfunction

    // Reference: shift the source mantissa field up or down by the width difference.
    task automatic model(input logic [63:0] s, input logic [1:0] sf, input logic [1:0] df,
                         input logic inv, input logic dm,
                         output logic [63:0] o, output logic fl);
        int ms = m_bits(sf);
        int md = m_bits(df);
        int ws = 1 + e_bits(sf) + ms;
        int wd = 1 + e_bits(df) + md;
        logic [63:0] m  = s & ((64'd1 << ms) - 64'd1);
        logic        ld = m[ms-1];
        logic        sg = s[ws-1];
        logic [63:0] om;
        fl = inv ? ld : (!ld && m != 64'd0);
        om = (md >= ms) ? (m << (md - ms)) : (m >> (ms - md));
        if (dm || om == 64'd0) o = dnan(df, inv);
        else o = ({63'd0, sg} << (wd - 1)) | (((64'd1 << e_bits(df)) - 64'd1) << md) | om;
    endtask

    task automatic cmp(input string tag, input logic [63:0] got_v, input logic got_f,
                       input logic [63:0] exp_v, input logic exp_f);
        n_tests++;
        if (got_v !== exp_v || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: got %h/%b expected %h/%b", tag, got_v, got_f, exp_v, exp_f);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] s, input logic [1:0] sf,
                       input logic [1:0] df, input logic inv, input logic dm);
        logic [63:0] eo;
        logic        ef;
        model(s, sf, df, inv, dm, eo, ef);
        @(negedge clk);
        src_val = s; src_fmt = sf; dst_fmt = df; snan_inv = inv; dflt_mode = dm;
        @(posedge clk);
        #1;
        cmp({tag, " reg"}, out_r, inv_r, eo, ef);
        cmp({tag, " comb"}, out_c, inv_c, eo, ef);
        last_out = out_r;
        last_flag = inv_r;
    endtask

    task automatic t_reset;
        @(negedge clk);
        src_val = 64'h7C01; src_fmt = 2'd0; dst_fmt = 2'd2;
        @(negedge clk);
        cmp("R11 reset value", out_r, inv_r, 64'd0, 1'b0);
        cmp("R11 comb during reset", out_c, inv_c, 64'h7FF0040000000000, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_same_fmt;
        run("R4 half->half quiet", 64'h7E55, 2'd0, 2'd0, 1'b0, 1'b0);
        run("R4 single->single neg", 64'hFFC12345, 2'd1, 2'd1, 1'b0, 1'b0);
        run("R2 double->double snan", 64'h7FF0000000000ABC, 2'd2, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_widen;
        run("R4 half->double snan", 64'h7C01, 2'd0, 2'd2, 1'b0, 1'b0);
        cmp("R4 R9 half->double literal", last_out, last_flag, 64'h7FF0040000000000, 1'b1);
        run("R4 single->double neg", 64'hFFE00001, 2'd1, 2'd2, 1'b0, 1'b0);
        run("R4 half->single", 64'hFF3F, 2'd0, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_narrow;
        run("R5 double->half", 64'h7FF8000000000001, 2'd2, 2'd0, 1'b0, 1'b0);
        cmp("R5 double->half literal", last_out, last_flag, 64'h7E00, 1'b0);
        run("R5 double->single", 64'hFFFABCDEF0123456, 2'd2, 2'd1, 1'b0, 1'b0);
        run("R5 single->half", 64'h7F8FFFFF, 2'd1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_trunc_zero;
        run("R6 double->half vanishes", 64'h7FF0000000000001, 2'd2, 2'd0, 1'b0, 1'b0);
        cmp("R6 literal", last_out, last_flag, 64'hFE00, 1'b1);
        run("R6 single->half vanishes inv", 64'h7F800001, 2'd1, 2'd0, 1'b1, 1'b0);
        cmp("R6 R3 inverted literal", last_out, last_flag, 64'h7DFF, 1'b0);
    endtask

    task automatic t_dflt;
        run("R7 dflt double sig", 64'h7FF4000000000000, 2'd2, 2'd2, 1'b0, 1'b1);
        cmp("R7 R8 literal", last_out, last_flag, 64'hFFF8000000000000, 1'b1);
        run("R8 dflt single inv", 64'h7FC00000, 2'd1, 2'd1, 1'b1, 1'b1);
        cmp("R8 single inv literal", last_out, last_flag, 64'h7FBFFFFF, 1'b1);
        run("R8 dflt half conv", 64'h7E00, 2'd0, 2'd0, 1'b0, 1'b1);
        cmp("R8 half literal", last_out, last_flag, 64'hFE00, 1'b0);
        run("R8 dflt double inv", 64'h7E00, 2'd0, 2'd2, 1'b1, 1'b1);
        cmp("R8 double inv literal", last_out, last_flag, 64'h7FF7FFFFFFFFFFFF, 1'b1);
    endtask

    task automatic t_inverted;
        run("R3 inv lead set", 64'h7FC00001, 2'd1, 2'd2, 1'b1, 1'b0);
        run("R3 inv lead clear", 64'h7FA00000, 2'd1, 2'd1, 1'b1, 1'b0);
        cmp("R3 quiet literal", last_out, last_flag, 64'h7FA00000, 1'b0);
    endtask

    task automatic t_no_silence;
        run("R9 single snan kept", 64'h7F800010, 2'd1, 2'd2, 1'b0, 1'b0);
        cmp("R9 literal", last_out, last_flag, 64'h7FF0000200000000, 1'b1);
    endtask

    task automatic t_upper_ignored;
        run("R10 half clean", 64'h7E01, 2'd0, 2'd1, 1'b0, 1'b0);
        run("R10 half dirty", 64'hDEADBEEF_ABCD7E01, 2'd0, 2'd1, 1'b0, 1'b0);
        cmp("R10 dirty literal", last_out, last_flag, 64'h7FC02000, 1'b0);
        run("R10 single dirty", 64'h12345678_7F800003, 2'd1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_rsvd;
        run("R1 code3 as double", 64'h7FF0000000100000, 2'd3, 2'd3, 1'b0, 1'b0);
        cmp("R1 code3 literal", last_out, last_flag, 64'h7FF0000000100000, 1'b1);
        run("R1 code3 to half", 64'h7FFC000000000000, 2'd3, 2'd0, 1'b0, 1'b0);
        cmp("R1 code3 half literal", last_out, last_flag, 64'h7F00, 1'b0);
    endtask

    task automatic t_sweep;
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                run("R4 R5 sweep pos", 64'h7FFF_FFA5_5A5A_7F81, 2'(a), 2'(b), 1'b0, 1'b0);
                run("R3 sweep inv", 64'hFFF5_0F0F_FFC0_0F0F, 2'(a), 2'(b), 1'b1, 1'b0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_same_fmt();
        t_widen();
        t_narrow();
        t_trunc_zero();
        t_dflt();
        t_inverted();
        t_no_silence();
        t_upper_ignored();
        t_rsvd();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule